// File: doc/BRIEF.md
# Byte-Wide SPI Target with Write-Collision Detection

This block is the target (slave) side of a serial peripheral link. It runs on a fast system clock. It watches the external serial clock, the active-low select and the controller-to-target data line through synchronizers. It moves one byte per transfer in each direction, most significant bit first. Two configuration bits set the clock idle level and the sampling phase, which gives the four usual clock modes.

Local logic loads the outgoing byte into a hold register. The byte that arrives is copied into a read register when its last bit has been sampled, and a done flag goes high at the same time. In phase-0 operation, select must frame each byte. A local write made while select is active in that mode is refused, and a collision flag is raised instead. The target-to-controller line is enabled only while select is active and the local enable bit is set. The enable output controls an external tri-state pad.

The serial clock must run at no more than one quarter of the system clock rate.

Top module: `spi_tgt_byte`

## Requirements
- R1: After reset, `rd_data` is 0x00, `done_flag` and `wcol_flag` are 0, and `miso_oe` is 0.
- R2: After the eighth sampling edge of a byte, `rd_data` holds the received byte and `done_flag` is 1. The received byte is assembled with the first bit on the wire as bit 7. This holds in all four clock modes.
- R3: `miso_out` presents the hold register, bit 7 first. In phase 0 (`cfg_cpha`=0), bit 7 is valid within 3 clocks of select going low, and each later bit appears after a trailing edge. In phase 1, each bit appears after a leading edge. The leading edge is the first edge away from the idle level.
- R4: `cfg_cpol` sets only the SCK idle level: 0 means idle low, 1 means idle high. The same bytes are exchanged for either value.
- R5: In phase 1, select may stay low across several bytes. The hold register is reloaded at the end of each byte, so a byte written during a transfer goes out in the next one.
- R6: In phase 0, a `wr_en` pulse while the synchronized select is low sets `wcol_flag` and leaves the hold register unchanged.
- R7: In phase 1, a `wr_en` pulse while select is low is accepted, and it does not set `wcol_flag`.
- R8: `miso_oe` is 1 only when `miso_oe_en` is 1 and select is low.
- R9: SCK edges are ignored while select is high. Raising select in the middle of a byte discards the partial byte, so the next byte starts again from its first bit.
- R10: A one-cycle `flag_clr` pulse clears both `done_flag` and `wcol_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Phase: 0 samples on the leading edge, 1 samples on the trailing edge |
| miso_oe_en | input | 1 | Local direction enable for the target-to-controller line |
| wr_en | input | 1 | Write strobe for the hold register |
| wr_data | input | 8 | Byte to transmit |
| flag_clr | input | 1 | Clear strobe for both flags |
| rd_data | output | 8 | Last received byte |
| done_flag | output | 1 | Byte transfer complete |
| wcol_flag | output | 1 | Write collision occurred |
| sck_in | input | 1 | Serial clock from the controller |
| ss_n_in | input | 1 | Active-low select |
| mosi_in | input | 1 | Controller-to-target data |
| miso_out | output | 1 | Target-to-controller data |
| miso_oe | output | 1 | Output enable for the miso pad |

## Verification
A bit counter that is off by one shows up at the ports within a single byte. The done flag rises on the wrong edge, and both `rd_data` and the serial output come out rotated. A confused leading/trailing edge decode moves the output data by half an SCK period, so the controller reads shifted bits on the very first transfer. A collision write that gets through to the hold register is only visible on the next phase-0 frame, when the refused byte comes out instead of the older one. The bench therefore runs a second frame after every collision.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  localparam int unsigned SPI_DW = 8;

  // edge that leaves the idle level
  function automatic logic lead_of(logic cpol, logic rise, logic fall);
    return cpol ? fall : rise;
  endfunction

  // edge that returns to the idle level
  function automatic logic trail_of(logic cpol, logic rise, logic fall);
    return cpol ? rise : fall;
  endfunction

  // phase 0 samples on the leading edge, phase 1 on the trailing edge
  function automatic logic samp_evt(logic cpha, logic lead, logic trail);
    return cpha ? trail : lead;
  endfunction

  function automatic logic drive_evt(logic cpha, logic lead, logic trail);
    return cpha ? lead : trail;
  endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_in,
  output logic [N-1:0] d_out
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
  import spi_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic cpol,
  output logic lead_evt,
  output logic trail_evt
);
  logic sck_d;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign rise      = sck_s & ~sck_d;
  assign fall      = ~sck_s & sck_d;
  assign lead_evt  = lead_of(cpol, rise, fall);
  assign trail_evt = trail_of(cpol, rise, fall);

  assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_evt && trail_evt));
endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW = SPI_DW,
  localparam int unsigned CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpha,
  input  logic          ss_s,
  input  logic          mosi_s,
  input  logic          lead_evt,
  input  logic          trail_evt,
  input  logic [DW-1:0] hold_q,
  output logic          out_bit,
  output logic          byte_done,
  output logic [DW-1:0] rx_byte
);
  logic [CW-1:0] cnt;
  logic [DW-1:0] tx_sh, rx_sh;
  logic          ss_d;
  logic          sel_start, samp, drive;
  logic [CW-1:0] idx;

  assign sel_start = ss_d & ~ss_s;
  assign samp      = ~ss_s & samp_evt(cpha, lead_evt, trail_evt);
  assign drive     = ~ss_s & drive_evt(cpha, lead_evt, trail_evt);
  assign idx       = CW'(DW - 1) - cnt;
  assign byte_done = samp && (cnt == CW'(DW - 1));
  assign rx_byte   = {rx_sh[DW-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      out_bit <= 1'b0;
      ss_d    <= 1'b1;
    end else begin
      ss_d <= ss_s;
      if (ss_s) begin
        cnt <= '0;
      end else if (sel_start) begin
        tx_sh   <= hold_q;
        out_bit <= hold_q[DW-1];
        cnt     <= '0;
      end else begin
        if (samp) begin
          rx_sh <= rx_byte;
          if (byte_done) begin
            cnt <= '0;
            if (cpha) tx_sh <= hold_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        if (drive && (cpha || cnt != '0)) out_bit <= tx_sh[idx];
      end
    end
  end

  assert_desel_cnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> (cnt == '0));
  assert_desel_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> $stable(rx_sh));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cpha) |=> (tx_sh == $past(hold_q)));
endmodule

// File: rtl/spi_tgt_byte.sv
module spi_tgt_byte
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DW = SPI_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          miso_oe_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          flag_clr,
  output logic [DW-1:0] rd_data,
  output logic          done_flag,
  output logic          wcol_flag,
  input  logic          sck_in,
  input  logic          ss_n_in,
  input  logic          mosi_in,
  output logic          miso_out,
  output logic          miso_oe
);
  logic          sck_s, ss_s, mosi_s;
  logic          lead_evt, trail_evt;
  logic          byte_done, wcol_evt;
  logic [DW-1:0] hold_q, rx_byte;

  // bit order: {sck, ss_n, mosi}; select resets inactive
  spi_tgt_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({sck_in, ss_n_in, mosi_in}),
    .d_out({sck_s, ss_s, mosi_s})
  );

  spi_tgt_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cpol(cfg_cpol),
    .lead_evt(lead_evt), .trail_evt(trail_evt)
  );

  spi_tgt_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cpha(cfg_cpha), .ss_s(ss_s), .mosi_s(mosi_s),
    .lead_evt(lead_evt), .trail_evt(trail_evt), .hold_q(hold_q),
    .out_bit(miso_out), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  assign wcol_evt = wr_en & ~cfg_cpha & ~ss_s;
  assign miso_oe  = miso_oe_en & ~ss_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      rd_data   <= '0;
      done_flag <= 1'b0;
      wcol_flag <= 1'b0;
    end else begin
      if (wr_en && !wcol_evt) hold_q <= wr_data;
      if (byte_done) rd_data <= rx_byte;
      if (byte_done)     done_flag <= 1'b1;
      else if (flag_clr) done_flag <= 1'b0;
      if (wcol_evt)      wcol_flag <= 1'b1;
      else if (flag_clr) wcol_flag <= 1'b0;
    end
  end

  assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (done_flag && rd_data == $past(rx_byte)));
  assert_wcol_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_evt |=> (wcol_flag && $stable(hold_q)));
  assert_wr_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_cpha) |=> (hold_q == $past(wr_data)));
  assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_s || !miso_oe_en) |-> !miso_oe);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !byte_done && !wcol_evt) |=> (!done_flag && !wcol_flag));
endmodule

// File: tb/spi_tgt_byte_tb_top.sv
`timescale 1ns/1ps
module spi_tgt_byte_tb_top;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0, miso_oe_en = 1'b1;
  logic       wr_en = 1'b0, flag_clr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       done_flag, wcol_flag;
  logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  logic       miso_out, miso_oe;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic done_prev = 1'b0;

  always #2 clk = ~clk;

  spi_tgt_byte dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .miso_oe_en(miso_oe_en), .wr_en(wr_en), .wr_data(wr_data),
    .flag_clr(flag_clr), .rd_data(rd_data), .done_flag(done_flag),
    .wcol_flag(wcol_flag), .sck_in(sck), .ss_n_in(ss_n), .mosi_in(mosi),
    .miso_out(miso_out), .miso_oe(miso_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: each rising done flag pops one expected received byte
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done_flag && !done_prev) begin
        if (exp_q.size() == 0) check("R2 unexpected done", 8'h01, 8'h00);
        else check("R2 rd_data", rd_data, exp_q.pop_front());
      end
      done_prev = done_flag;
    end
  end

  task automatic set_mode(input logic pol, input logic pha);
    cfg_cpol = pol; cfg_cpha = pha; sck = pol;
    wait_clk(6);
  endtask

  task automatic write_hold(input logic [7:0] v);
    wr_data = v; wr_en = 1'b1; wait_clk(1); wr_en = 1'b0; wait_clk(1);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; wait_clk(1); flag_clr = 1'b0; wait_clk(1);
  endtask

  task automatic select(input logic lvl);
    ss_n = lvl; wait_clk(2 * HALF);
  endtask

  // one byte with select already low; queues the expected rd_data
  task automatic xfer(input logic [7:0] mtx, input logic [7:0] exp_so, input string tag);
    logic [7:0] got;
    exp_q.push_back(mtx);
    for (int i = 7; i >= 0; i--) begin
      if (!cfg_cpha) begin
        mosi = mtx[i]; wait_clk(HALF); got[i] = miso_out;
        sck = ~cfg_cpol; wait_clk(HALF); sck = cfg_cpol;
      end else begin
        sck = ~cfg_cpol; mosi = mtx[i]; wait_clk(HALF); got[i] = miso_out;
        sck = cfg_cpol; wait_clk(HALF);
      end
    end
    wait_clk(HALF);
    check({tag, " miso byte"}, got, exp_so);
    check("R2 done_flag", {7'b0, done_flag}, 8'h01);
  endtask

  initial begin
    @(negedge clk); wait_clk(3);
    // R1 reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 flags", {6'b0, done_flag, wcol_flag}, 8'h00);
    check("R1 miso_oe", {7'b0, miso_oe}, 8'h00);
    rst_n = 1'b1; wait_clk(4);

    // R2 R3 mode 0
    set_mode(1'b0, 1'b0);
    write_hold(8'hA5);
    select(1'b0);
    check("R8 oe active", {7'b0, miso_oe}, 8'h01);
    xfer(8'h3C, 8'hA5, "R3 mode0");
    select(1'b1); clear_flags();
    check("R8 oe idle", {7'b0, miso_oe}, 8'h00);

    // R4 polarity 1, phase 0
    set_mode(1'b1, 1'b0);
    write_hold(8'hA5);
    select(1'b0); xfer(8'h3C, 8'hA5, "R4 mode2"); select(1'b1); clear_flags();

    // R3 phase 1, both polarities
    set_mode(1'b0, 1'b1);
    write_hold(8'h81);
    select(1'b0); xfer(8'h7E, 8'h81, "R3 mode1"); select(1'b1); clear_flags();
    set_mode(1'b1, 1'b1);
    write_hold(8'h81);
    select(1'b0); xfer(8'h7E, 8'h81, "R4 mode3"); select(1'b1); clear_flags();

    // R5 R7 back-to-back in phase 1, write during transfer
    write_hold(8'h12);
    select(1'b0);
    write_hold(8'hC3);
    check("R7 no wcol", {7'b0, wcol_flag}, 8'h00);
    xfer(8'h55, 8'h12, "R5 byte1"); clear_flags();
    xfer(8'hF0, 8'hC3, "R5 byte2"); clear_flags();
    select(1'b1);

    // R6 collision in phase 0
    set_mode(1'b0, 1'b0);
    write_hold(8'h5A);
    select(1'b0);
    write_hold(8'hFF);
    check("R6 wcol set", {7'b0, wcol_flag}, 8'h01);
    xfer(8'h01, 8'h5A, "R6 frame1");
    select(1'b1);
    // R10 clear both flags
    clear_flags();
    check("R10 flags cleared", {6'b0, done_flag, wcol_flag}, 8'h00);
    select(1'b0); xfer(8'h80, 8'h5A, "R6 write dropped"); select(1'b1); clear_flags();

    // R8 enable off while selected
    miso_oe_en = 1'b0; select(1'b0);
    check("R8 oe disabled", {7'b0, miso_oe}, 8'h00);
    select(1'b1); miso_oe_en = 1'b1;

    // R9 edges while deselected ignored
    mosi = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
    end
    check("R9 no done", {7'b0, done_flag}, 8'h00);
    check("R9 rd kept", rd_data, 8'h80);
    // R9 partial byte then restart
    select(1'b0);
    for (int k = 0; k < 3; k++) begin
      mosi = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    wait_clk(HALF);
    select(1'b1);
    check("R9 partial no done", {7'b0, done_flag}, 8'h00);
    select(1'b0); xfer(8'h96, 8'h5A, "R9 restart"); select(1'b1); clear_flags();

    wait_clk(10);
    check("R2 queue drained", 8'(exp_q.size()), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule